// File: doc/BRIEF.md
# Controller Register Access Unit

This block serves read-register and set-register requests that processor ports send to a memory controller. Each request carries an instruction address, a write payload split into an upper and a lower 36-bit half, and the number of the port that sent it. The block decodes a register select field from the address. For a read it returns 72 bits in the same two-half layout. For a set it updates the targeted register, applying protection field by field.

Five registers are held or synthesized here: a mode register carrying the controller identity, a configuration register, an interrupt enable register, a bank of 32 interrupt cells, and a 52-bit free-running clock that can be set. A store-unit mode register can be included through a parameter. Some read fields come from the request or from pins rather than from storage: the requesting port number and the program/manual switch. The configuration register can only be changed while that switch is in program position. Every request, legal or not, completes with a single-cycle response strobe.

Top module: `ctlreg_access_unit`

## Requirements
- R1: A request sampled at a clock edge produces `rsp_valid` high for exactly one cycle after that edge, and there is no strobe without a request. A set-register request returns all-zero data with `rsp_illegal` low. A read returns register contents as they were before any write made at the same edge.
- R2: The register is selected by address bits [5:3] (0 mode, 1 configuration, 2 interrupt enable, 3 interrupt cells, 4 clock, 6 store-unit mode). Bits [14:6] must be zero. Bits [2:0] and bits above 14 are ignored.
- R3: A select value of 5 or 7, or a non-zero value in bits [14:6], gives `rsp_illegal` high and all-zero data, and changes no register.
- R4: Mode register: the upper half reads zero. The lower half holds the identity code 4'b0010 in bits [21:18] and writable storage in bits [17:1]. All other bits read zero.
- R5: Configuration upper bits [19:16] return the `req_port` value of the read itself. A write never stores them.
- R6: Configuration upper bit 14 reads `prog_mode_sw`. While `prog_mode_sw` is 0, a configuration write leaves every field unchanged. While it is 1, all settable fields take the written value.
- R7: Configuration layout. Upper half: [35:27] mask-A assignment, [26:24] store size, [23:20] store units online, [13] nonexistent-address enable, [12:6] nonexistent-address base, [5] interlace, [4] low-order store, [3:0] port enables 0-3; bit 15 reads zero. Lower half: [35:27] mask-B assignment, [14:8] cyclic priority, [3:0] port enables 4-7; [26:15] and [7:4] read zero.
- R8: Interrupt enable register: enables 0-15 sit in upper [35:20] and enables 16-31 in lower [35:20]. Upper [3:0] and lower [3:0] show the configuration port enables 0-3 and 4-7. All other bits read zero. A write here updates only the 32 enable bits.
- R9: Interrupt cells: cells 0-15 sit in upper [35:20] and cells 16-31 in lower [35:20], with all other bits zero. A write replaces all 32 cells.
- R10: The clock reads as upper [15:0] = clock[51:36] and lower = clock[35:0], with upper [35:16] zero. A set loads {upper[15:0], lower}. The new value lands one cycle after the response strobe, so a read at the very next edge still returns the old value.
- R11: While `tick_en` is high and no load is landing, the clock adds one per cycle and wraps from all ones to zero. It holds while `tick_en` is low.
- R12: Store-unit mode register: the upper half reads zero and the lower half bits [21:18] read the parameter code (default 4'b1111). Writable bits are [35:22], [17], [12:5], [3:2] and [0]. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = set register, 0 = read register |
| req_addr | input | ADDR_W (18) | Instruction address; bits [14:3] form the select field |
| req_wdata_hi | input | 36 | Upper half of the write payload |
| req_wdata_lo | input | 36 | Lower half of the write payload |
| req_port | input | PORT_W (4) | Number of the requesting port |
| prog_mode_sw | input | 1 | Program/manual switch; 1 permits configuration writes |
| tick_en | input | 1 | Clock advance enable |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_illegal | output | 1 | Unimplemented register selected |
| rsp_rdata_hi | output | 36 | Upper half of the read payload |
| rsp_rdata_lo | output | 36 | Lower half of the read payload |

## Verification
Registers are written with all ones and then with alternating, asymmetric field patterns. All ones shows which bits are settable and which are forced. The asymmetric patterns expose swapped or misplaced fields between the two halves. Configuration writes are repeated with the switch in each position, and with the port field written as ones and read from different ports, to separate stored data from reflected data. Clock sets are followed by an immediate read and a delayed read to pin the landing cycle. A carry across the 36-bit boundary and a wrap from all ones test the counter. Reads and writes with the ignored address bits set or the high select bits non-zero separate the decoding of the select field from the rejection of unimplemented registers.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

   localparam int unsigned HALF_W  = 36;
   localparam int unsigned SEL_LSB = 3;
   localparam int unsigned SEL_MSB = 14;
   localparam int unsigned DIG_W   = 3;
   localparam int unsigned HI_W    = SEL_MSB - SEL_LSB + 1 - DIG_W;
   localparam int unsigned ID_LSB  = 18;

   typedef enum logic [DIG_W-1:0] {
      SEL_MODE  = 3'd0,
      SEL_CFG   = 3'd1,
      SEL_IEN   = 3'd2,
      SEL_CELLS = 3'd3,
      SEL_CLOCK = 3'd4,
      SEL_RSV5  = 3'd5,
      SEL_SU    = 3'd6,
      SEL_RSV7  = 3'd7
   } reg_sel_e;

   typedef struct packed {
      logic [8:0] asg_a;
      logic [2:0] store_size;
      logic [3:0] unit_on;
      logic       nx_en;
      logic [6:0] nx_base;
      logic       interleave;
      logic       low_sel;
      logic [3:0] port_en_lo;
      logic [8:0] asg_b;
      logic [6:0] prio_cyc;
      logic [3:0] port_en_hi;
   } cfg_fields_t;

   localparam logic [HALF_W-1:0] SU_WMASK =
      {6'h3F, 8'hFF, 4'h0, 1'b1, 4'h0, 8'hFF, 1'b0, 2'b11, 1'b0, 1'b1};

endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
   import ctlreg_pkg::*;
#(
   parameter bit SU_EN = 1'b1
)(
   input  logic [SEL_MSB-SEL_LSB:0] sel_field,
   output reg_sel_e                 sel,
   output logic                     legal
);

   logic [DIG_W-1:0] digit;
   logic [HI_W-1:0]  hi_bits;
   logic             known;

   assign digit   = sel_field[DIG_W-1:0];
   assign hi_bits = sel_field[SEL_MSB-SEL_LSB:DIG_W];
   assign sel     = reg_sel_e'(digit);

   always_comb begin
      case (sel)
         SEL_MODE, SEL_CFG, SEL_IEN, SEL_CELLS, SEL_CLOCK: known = 1'b1;
         SEL_SU:                                          known = SU_EN;
         default:                                         known = 1'b0;
      endcase
   end

   assign legal = known && (hi_bits == '0);

endmodule

// File: rtl/ctlreg_clock.sv
module ctlreg_clock #(
   parameter int unsigned CLK_W = 52
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ld_req,
   input  logic [CLK_W-1:0] ld_val,
   output logic [CLK_W-1:0] cnt
);

   localparam logic [CLK_W-1:0] ONE = {{(CLK_W-1){1'b0}}, 1'b1};

   generate
      if (CLK_W < 2) begin : g_bad_w
         $error("ctlreg_clock: CLK_W must be at least 2");
      end
   endgenerate

   logic             pend;
   logic [CLK_W-1:0] pend_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         pend     <= 1'b0;
         pend_val <= '0;
      end else begin
         pend <= ld_req;
         if (ld_req) pend_val <= ld_val;
         if (pend)      cnt <= pend_val;
         else if (tick) cnt <= cnt + ONE;
      end
   end

   // R11
   tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !pend) |=> (cnt == $past(cnt) + ONE));

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !pend) |=> $stable(cnt));

   // R10
   load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_req |=> ##1 (cnt == $past(ld_val, 2)));

endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
   import ctlreg_pkg::*;
#(
   parameter int unsigned PORT_W  = 4,
   parameter int unsigned CLK_W   = 52,
   parameter logic [3:0]  CTRL_ID = 4'b0010,
   parameter logic [3:0]  SU_ID   = 4'b1111,
   parameter bit          SU_EN   = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              wr,
   input  reg_sel_e          sel,
   input  logic [HALF_W-1:0] wr_up,
   input  logic [HALF_W-1:0] wr_lo,
   input  logic [PORT_W-1:0] req_port,
   input  logic              prog_mode,
   input  logic [CLK_W-1:0]  clk_cnt,
   output logic [HALF_W-1:0] rd_up,
   output logic [HALF_W-1:0] rd_lo,
   output logic              clk_ld,
   output logic [CLK_W-1:0]  clk_ld_val
);

   localparam int unsigned CLK_HI_W = CLK_W - HALF_W;
   localparam int unsigned MODE_W   = ID_LSB - 1;
   localparam int unsigned CELLS    = 32;
   localparam int unsigned CELL_H   = CELLS / 2;
   localparam int unsigned CELL_PAD = HALF_W - CELL_H;

   generate
      if (PORT_W != 4) begin : g_bad_port
         $error("ctlreg_bank: the port field is four bits wide");
      end
      if (CLK_W <= HALF_W || CLK_HI_W > 16) begin : g_bad_clk
         $error("ctlreg_bank: CLK_W must lie in 37..52");
      end
   endgenerate

   logic wr_en;
   logic wr_unused;

   assign wr_en     = acc && wr;
   assign wr_unused = ^wr_up;

   // ---------------- mode register
   logic [MODE_W-1:0] mode_q;
   logic [HALF_W-1:0] mode_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         mode_q <= '0;
      else if (wr_en && sel == SEL_MODE)  mode_q <= wr_lo[ID_LSB-1:1];
   end
   assign mode_rd = {{(HALF_W-ID_LSB-4){1'b0}}, CTRL_ID, mode_q, 1'b0};

   // ---------------- configuration register
   cfg_fields_t cfg_q, cfg_d;
   logic [HALF_W-1:0] cfg_rd_up, cfg_rd_lo;

   always_comb begin
      cfg_d            = cfg_q;
      cfg_d.asg_a      = wr_up[35:27];
      cfg_d.store_size = wr_up[26:24];
      cfg_d.unit_on    = wr_up[23:20];
      cfg_d.nx_en      = wr_up[13];
      cfg_d.nx_base    = wr_up[12:6];
      cfg_d.interleave = wr_up[5];
      cfg_d.low_sel    = wr_up[4];
      cfg_d.port_en_lo = wr_up[3:0];
      cfg_d.asg_b      = wr_lo[35:27];
      cfg_d.prio_cyc   = wr_lo[14:8];
      cfg_d.port_en_hi = wr_lo[3:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        cfg_q <= '0;
      else if (wr_en && sel == SEL_CFG && prog_mode)     cfg_q <= cfg_d;
   end

   assign cfg_rd_up = {cfg_q.asg_a, cfg_q.store_size, cfg_q.unit_on, req_port,
                       1'b0, prog_mode, cfg_q.nx_en, cfg_q.nx_base,
                       cfg_q.interleave, cfg_q.low_sel, cfg_q.port_en_lo};
   assign cfg_rd_lo = {cfg_q.asg_b, 12'h000, cfg_q.prio_cyc, 4'h0, cfg_q.port_en_hi};

   // ---------------- interrupt enables and cells
   logic [CELLS-1:0] ien_q, cell_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q  <= '0;
         cell_q <= '0;
      end else if (wr_en) begin
         if (sel == SEL_IEN)
            ien_q <= {wr_lo[HALF_W-1:CELL_PAD], wr_up[HALF_W-1:CELL_PAD]};
         if (sel == SEL_CELLS)
            cell_q <= {wr_lo[HALF_W-1:CELL_PAD], wr_up[HALF_W-1:CELL_PAD]};
      end
   end

   // ---------------- store-unit mode register (optional)
   logic [HALF_W-1:0] su_rd;

   generate
      if (SU_EN) begin : g_su
         logic [HALF_W-1:0] su_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       su_q <= '0;
            else if (wr_en && sel == SEL_SU)  su_q <= wr_lo & SU_WMASK;
         end
         assign su_rd = su_q | {{(HALF_W-ID_LSB-4){1'b0}}, SU_ID, {ID_LSB{1'b0}}};
      end else begin : g_no_su
         assign su_rd = '0;
      end
   endgenerate

   // ---------------- clock load path
   assign clk_ld     = wr_en && sel == SEL_CLOCK;
   assign clk_ld_val = {wr_up[CLK_HI_W-1:0], wr_lo};

   // ---------------- read mux
   always_comb begin
      rd_up = '0;
      rd_lo = '0;
      case (sel)
         SEL_MODE:  rd_lo = mode_rd;
         SEL_CFG: begin
            rd_up = cfg_rd_up;
            rd_lo = cfg_rd_lo;
         end
         SEL_IEN: begin
            rd_up = {ien_q[CELL_H-1:0], {(CELL_PAD-4){1'b0}}, cfg_q.port_en_lo};
            rd_lo = {ien_q[CELLS-1:CELL_H], {(CELL_PAD-4){1'b0}}, cfg_q.port_en_hi};
         end
         SEL_CELLS: begin
            rd_up = {cell_q[CELL_H-1:0], {CELL_PAD{1'b0}}};
            rd_lo = {cell_q[CELLS-1:CELL_H], {CELL_PAD{1'b0}}};
         end
         SEL_CLOCK: begin
            rd_up = {{(HALF_W-CLK_HI_W){1'b0}}, clk_cnt[CLK_W-1:HALF_W]};
            rd_lo = clk_cnt[HALF_W-1:0];
         end
         SEL_SU:    rd_lo = su_rd;
         default: begin
            rd_up = '0;
            rd_lo = '0;
         end
      endcase
   end

   // R6
   cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_CFG && !prog_mode) |=> $stable(cfg_q));

   // R8
   port_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_IEN) |=> ($stable(cfg_q.port_en_lo) && $stable(cfg_q.port_en_hi)));

   // R3
   no_access_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> ($stable(cfg_q) && $stable(ien_q) && $stable(cell_q) && $stable(mode_q)));

endmodule

// File: rtl/ctlreg_access_unit.sv
module ctlreg_access_unit
   import ctlreg_pkg::*;
#(
   parameter int unsigned ADDR_W  = 18,
   parameter int unsigned PORT_W  = 4,
   parameter int unsigned CLK_W   = 52,
   parameter logic [3:0]  CTRL_ID = 4'b0010,
   parameter logic [3:0]  SU_ID   = 4'b1111,
   parameter bit          SU_EN   = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [HALF_W-1:0] req_wdata_hi,
   input  logic [HALF_W-1:0] req_wdata_lo,
   input  logic [PORT_W-1:0] req_port,
   input  logic              prog_mode_sw,
   input  logic              tick_en,
   output logic              rsp_valid,
   output logic              rsp_illegal,
   output logic [HALF_W-1:0] rsp_rdata_hi,
   output logic [HALF_W-1:0] rsp_rdata_lo
);

   generate
      if (ADDR_W <= SEL_MSB + 1) begin : g_bad_addr
         $error("ctlreg_access_unit: ADDR_W must exceed the select field");
      end
   endgenerate

   reg_sel_e          sel;
   logic              legal;
   logic              acc;
   logic              addr_unused;
   logic [HALF_W-1:0] rd_up, rd_lo;
   logic              clk_ld;
   logic [CLK_W-1:0]  clk_ld_val;
   logic [CLK_W-1:0]  clk_cnt;

   assign addr_unused = ^{req_addr[ADDR_W-1:SEL_MSB+1], req_addr[SEL_LSB-1:0]};
   assign acc         = req_valid && legal;

   ctlreg_decode #(.SU_EN(SU_EN)) u_decode (
      .sel_field (req_addr[SEL_MSB:SEL_LSB]),
      .sel       (sel),
      .legal     (legal)
   );

   ctlreg_bank #(
      .PORT_W  (PORT_W),
      .CLK_W   (CLK_W),
      .CTRL_ID (CTRL_ID),
      .SU_ID   (SU_ID),
      .SU_EN   (SU_EN)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc        (acc),
      .wr         (req_write),
      .sel        (sel),
      .wr_up      (req_wdata_hi),
      .wr_lo      (req_wdata_lo),
      .req_port   (req_port),
      .prog_mode  (prog_mode_sw),
      .clk_cnt    (clk_cnt),
      .rd_up      (rd_up),
      .rd_lo      (rd_lo),
      .clk_ld     (clk_ld),
      .clk_ld_val (clk_ld_val)
   );

   ctlreg_clock #(.CLK_W(CLK_W)) u_clock (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_en),
      .ld_req (clk_ld),
      .ld_val (clk_ld_val),
      .cnt    (clk_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_illegal  <= 1'b0;
         rsp_rdata_hi <= '0;
         rsp_rdata_lo <= '0;
      end else begin
         rsp_valid   <= req_valid;
         rsp_illegal <= req_valid && !legal;
         if (acc && !req_write) begin
            rsp_rdata_hi <= rd_up;
            rsp_rdata_lo <= rd_lo;
         end else begin
            rsp_rdata_hi <= '0;
            rsp_rdata_lo <= '0;
         end
      end
   end

   // R1
   strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R1
   strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R1
   write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> (rsp_rdata_hi == '0 && rsp_rdata_lo == '0));

   // R3
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_illegal |-> (rsp_valid && rsp_rdata_hi == '0 && rsp_rdata_lo == '0));

endmodule

// File: tb/ctlreg_access_unit_bench.sv
module ctlreg_access_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write, prog_mode_sw, tick_en;
   logic [17:0] req_addr;
   logic [35:0] req_wdata_hi, req_wdata_lo;
   logic [3:0]  req_port;
   logic        rsp_valid, rsp_illegal;
   logic [35:0] rsp_rdata_hi, rsp_rdata_lo;

   always #5 clk = ~clk;

   ctlreg_access_unit u_ctlreg_access_unit (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_write    (req_write),
      .req_addr     (req_addr),
      .req_wdata_hi (req_wdata_hi),
      .req_wdata_lo (req_wdata_lo),
      .req_port     (req_port),
      .prog_mode_sw (prog_mode_sw),
      .tick_en      (tick_en),
      .rsp_valid    (rsp_valid),
      .rsp_illegal  (rsp_illegal),
      .rsp_rdata_hi (rsp_rdata_hi),
      .rsp_rdata_lo (rsp_rdata_lo)
   );

   typedef struct {
      logic [35:0] up;
      logic [35:0] lo;
      bit          ill;
      string       tag;
   } exp_t;

   exp_t sb[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   localparam logic [35:0] ONES = '1;
   localparam logic [35:0] Z    = '0;

   function automatic logic [17:0] mk(input logic [2:0] dg, input logic [8:0] hi = 9'h0,
                                      input logic [2:0] low3 = 3'h0, input logic [2:0] top3 = 3'h0);
      return {top3, hi, dg, low3};
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   // monitor: pops expected items as responses appear
   always @(negedge clk) begin
      if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
         n_chk++;
         if (sb.size() == 0) begin
            n_bad++;
            $display("FAIL R1 spurious strobe: got valid=1, expected valid=0");
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (rsp_rdata_hi !== e.up || rsp_rdata_lo !== e.lo || rsp_illegal !== e.ill) begin
               n_bad++;
               $display("FAIL %s: got hi=%h lo=%h ill=%0b, expected hi=%h lo=%h ill=%0b",
                        e.tag, rsp_rdata_hi, rsp_rdata_lo, rsp_illegal, e.up, e.lo, e.ill);
            end
         end
      end
   end

   // driver: called at a falling edge, returns at the next falling edge
   task automatic do_req(input bit wr, input logic [17:0] a, input logic [35:0] wu, input logic [35:0] wl,
                         input logic [3:0] port, input logic [35:0] eu, input logic [35:0] el,
                         input bit ill, input string tag);
      exp_t e;
      e.up = eu; e.lo = el; e.ill = ill; e.tag = tag;
      sb.push_back(e);
      req_valid    = 1'b1;
      req_write    = wr;
      req_addr     = a;
      req_wdata_hi = wu;
      req_wdata_lo = wl;
      req_port     = port;
      @(negedge clk);
      req_valid    = 1'b0;
      req_write    = 1'b0;
   endtask

   task automatic tick_n(input int n);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got no end of run, expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
      req_wdata_hi = '0; req_wdata_lo = '0; req_port = '0;
      prog_mode_sw = 1'b0; tick_en = 1'b0;
      repeat (3) @(negedge clk);
      n_chk++;
      if (rsp_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 reset: got valid=%0b, expected valid=0", rsp_valid);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R4 reset contents of the mode register
      do_req(0, mk(3'd0), Z, Z, 4'd0, Z, 36'h0_0008_0000, 0, "R4 mode after reset");
      // R4 / R1 write all ones; write response is zero
      do_req(1, mk(3'd0), ONES, ONES, 4'd0, Z, Z, 0, "R1 write response");
      do_req(0, mk(3'd0), Z, Z, 4'd0, Z, 36'h0_000B_FFFE, 0, "R4 mode settable bits");
      // R2 ignored address bits
      do_req(1, mk(3'd0, 9'h0, 3'b111, 3'b101), Z, 36'h0_0000_AAAA, 4'd0, Z, Z, 0, "R2 write ignore bits");
      do_req(0, mk(3'd0, 9'h0, 3'b010, 3'b011), Z, Z, 4'd0, Z, 36'h0_0008_AAAA, 0, "R2 read ignore bits");
      // R3 unimplemented selects
      do_req(0, mk(3'd5), Z, Z, 4'd0, Z, Z, 1, "R3 read select 5");
      do_req(1, mk(3'd7), ONES, ONES, 4'd0, Z, Z, 1, "R3 write select 7");
      do_req(1, mk(3'd0, 9'h001), Z, Z, 4'd0, Z, Z, 1, "R3 write high select bits");
      do_req(0, mk(3'd0, 9'h100), Z, Z, 4'd0, Z, Z, 1, "R3 read high select bits");
      do_req(0, mk(3'd0), Z, Z, 4'd0, Z, 36'h0_0008_AAAA, 0, "R3 mode untouched");

      // R6 writes ignored in manual position; R5 port reflected
      do_req(1, mk(3'd1), ONES, ONES, 4'd3, Z, Z, 0, "R6 locked write");
      do_req(0, mk(3'd1), Z, Z, 4'd5, 36'h0_0005_0000, Z, 0, "R6 locked readback / R5 port 5");
      prog_mode_sw = 1'b1;
      do_req(0, mk(3'd1), Z, Z, 4'd2, 36'h0_0002_4000, Z, 0, "R6 switch bit / R5 port 2");
      do_req(1, mk(3'd1), ONES, ONES, 4'd1, Z, Z, 0, "R7 open write");
      do_req(0, mk(3'd1), Z, Z, 4'd9,
             {16'hFFFF, 4'h9, 1'b0, 1'b1, 14'h3FFF},
             {9'h1FF, 12'h000, 7'h7F, 4'h0, 4'hF}, 0, "R7 all-ones layout / R5 port 9");

      // R8 enables and reflected port enables
      do_req(0, mk(3'd2), Z, Z, 4'd0, {16'h0, 16'h0, 4'hF}, {16'h0, 16'h0, 4'hF}, 0, "R8 port enables shown");
      do_req(1, mk(3'd2), {16'hA5A5, 20'h0}, {16'h3C3C, 20'h0}, 4'd0, Z, Z, 0, "R8 enable write");
      do_req(0, mk(3'd2), Z, Z, 4'd0, {16'hA5A5, 16'h0, 4'hF}, {16'h3C3C, 16'h0, 4'hF}, 0, "R8 port enables kept");

      // R7 asymmetric pattern
      do_req(1, mk(3'd1), {9'h155, 3'b101, 4'b1001, 4'hF, 1'b0, 1'b0, 1'b1, 7'h33, 1'b0, 1'b1, 4'h5},
             {9'h0AB, 12'hFFF, 7'h2A, 4'hF, 4'hA}, 4'd0, Z, Z, 0, "R7 pattern write");
      do_req(0, mk(3'd1), Z, Z, 4'd6,
             {9'h155, 3'b101, 4'b1001, 4'h6, 1'b0, 1'b1, 1'b1, 7'h33, 1'b0, 1'b1, 4'h5},
             {9'h0AB, 12'h000, 7'h2A, 4'h0, 4'hA}, 0, "R7 pattern readback");
      do_req(0, mk(3'd2), Z, Z, 4'd0, {16'hA5A5, 16'h0, 4'h5}, {16'h3C3C, 16'h0, 4'hA}, 0, "R8 new port enables");
      prog_mode_sw = 1'b0;
      do_req(1, mk(3'd1), Z, Z, 4'd0, Z, Z, 0, "R6 locked zero write");
      do_req(0, mk(3'd1), Z, Z, 4'd6,
             {9'h155, 3'b101, 4'b1001, 4'h6, 1'b0, 1'b0, 1'b1, 7'h33, 1'b0, 1'b1, 4'h5},
             {9'h0AB, 12'h000, 7'h2A, 4'h0, 4'hA}, 0, "R6 fields held");

      // R9 interrupt cells
      do_req(1, mk(3'd3), {16'h1234, 20'hFFFFF}, {16'hBEEF, 20'hFFFFF}, 4'd0, Z, Z, 0, "R9 cell write");
      do_req(0, mk(3'd3), Z, Z, 4'd0, {16'h1234, 20'h0}, {16'hBEEF, 20'h0}, 0, "R9 cell layout");
      do_req(1, mk(3'd3), {16'h0001, 20'h0}, {16'h8000, 20'h0}, 4'd0, Z, Z, 0, "R9 cell replace");
      do_req(0, mk(3'd3), Z, Z, 4'd0, {16'h0001, 20'h0}, {16'h8000, 20'h0}, 0, "R9 cells replaced");

      // R10 clock set and landing cycle
      do_req(1, mk(3'd4), 36'hF_FFFF_ABCD, 36'h1_2345_6789, 4'd0, Z, Z, 0, "R10 clock set");
      do_req(0, mk(3'd4), Z, Z, 4'd0, Z, Z, 0, "R10 old value at next edge");
      do_req(0, mk(3'd4), Z, Z, 4'd0, 36'h0_0000_ABCD, 36'h1_2345_6789, 0, "R10 new value");
      // R11 carry across halves
      do_req(1, mk(3'd4), 36'h0_0000_0001, ONES, 4'd0, Z, Z, 0, "R11 clock set");
      do_req(0, mk(3'd4), Z, Z, 4'd0, 36'h0_0000_ABCD, 36'h1_2345_6789, 0, "R10 old value again");
      tick_n(5);
      do_req(0, mk(3'd4), Z, Z, 4'd0, 36'h0_0000_0002, 36'h0_0000_0004, 0, "R11 carry into upper");
      // R11 wrap
      do_req(1, mk(3'd4), 36'h0_0000_FFFF, ONES, 4'd0, Z, Z, 0, "R11 set all ones");
      do_req(0, mk(3'd4), Z, Z, 4'd0, 36'h0_0000_0002, 36'h0_0000_0004, 0, "R11 hold without tick");
      do_req(0, mk(3'd4), Z, Z, 4'd0, 36'h0_0000_FFFF, ONES, 0, "R11 all ones landed");
      tick_n(1);
      do_req(0, mk(3'd4), Z, Z, 4'd0, Z, Z, 0, "R11 wrap to zero");

      // R12 store-unit mode register
      do_req(0, mk(3'd6), Z, Z, 4'd0, Z, {14'h0, 4'hF, 18'h0}, 0, "R12 reset id");
      do_req(1, mk(3'd6), ONES, ONES, 4'd0, Z, Z, 0, "R12 write ones");
      do_req(0, mk(3'd6), Z, Z, 4'd0, Z,
             {6'h3F, 8'hFF, 4'hF, 1'b1, 4'h0, 8'hFF, 1'b0, 2'b11, 1'b0, 1'b1}, 0, "R12 settable bits");

      repeat (3) @(negedge clk);
      n_chk++;
      if (sb.size() != 0) begin
         n_bad++;
         $display("FAIL R1 missing strobes: got %0d pending, expected 0", sb.size());
      end
      finish_run();
   end

endmodule